// File: doc/BRIEF.md
# Stop-Mode Wakeup and Stabilization Controller

This block parks the chip in a deep low-power state with both the main oscillator and the internal oscillator gated off, then brings it back when a release source fires. Release sources are one non-maskable request line and a parameterized set of maskable requests. Each maskable request has its own mask bit and priority level. All logic runs on a free-running reference clock that stays alive while the main clocks are stopped.

When a release source fires, the controller re-enables both oscillators and counts a programmable settling interval on the reference clock. It then emits a single-cycle resume pulse. The pulse tells the CPU either to branch to the handler of the winning source (`ack_valid` with `ack_id`) or to carry on at the next instruction (`next_instr`). Whether the wake is acknowledged depends on the global enable flag and on the priority of any service routine that was running when stop was entered. A wake that is not acknowledged leaves its source recorded as held.

Top module: `stopwake_ctrl`

## Requirements
- R1: In stop, the block leaves stop on the next clock edge when `nmi_req` is 1 or any `irq_req[i]` is 1 with `irq_mask[i]` = 0, at any priority. A request with mask bit 1 does not release stop.
- R2: While `stopped` is 1, `main_clk_en` and `int_osc_en` are both 0.
- R3: After the edge that samples the release, `stabilizing` is 1 and both clock enables are 1. The resume pulse appears exactly 2^(10+S) reference cycles after that edge, where S is the `stab_sel` value captured at stop entry.
- R4: Suppose `isr_active` was 1 and the winning maskable request has a priority value less than or equal to `isr_prio`. Then the block resumes with `next_instr` and no acknowledge, and sets `held_valid` = 1 with `held_id` equal to that source index. The held record stays until the next stop entry.
- R5: A winning request whose priority value is greater than `isr_prio`, or a non-maskable request, is acknowledged with `ack_valid` = 1 when `int_en` = 1. The non-maskable source is reported as `ack_id` = N_IRQ.
- R6: With `int_en` = 0, a maskable wake resumes with `next_instr` and never with `ack_valid`. A non-maskable wake is still acknowledged.
- R7: With `int_en` = 1 and `isr_active` = 0, a maskable wake is acknowledged, and only after the full settling interval.
- R8: `ack_valid` and `next_instr` are never 1 together, and each is a single-cycle pulse.
- R9: If a release source is present in the same cycle as `stop_req`, stop is not entered. The clocks stay on and no resume pulse is produced.
- R10: Among simultaneous sources, the non-maskable request wins. Otherwise the unmasked request with the largest priority value wins, and ties go to the lowest index.
- R11: After reset the block is running with both clock enables at 1, no resume pulse, and `held_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Command to enter stop |
| nmi_req | input | 1 | Non-maskable release request |
| irq_req | input | N_IRQ | Maskable requests |
| irq_mask | input | N_IRQ | Mask bits, 1 = masked |
| irq_prio | input | N_IRQ*PRIO_W | Priority per request, source i in bits [i*PRIO_W +: PRIO_W], larger is higher |
| isr_active | input | 1 | A service routine was running at stop entry |
| isr_prio | input | PRIO_W | Priority of the running service routine |
| int_en | input | 1 | Global interrupt enable |
| stab_sel | input | SEL_W | Settling interval select S, interval 2^(BASE_EXP+S) |
| main_clk_en | output | 1 | Main oscillator enable |
| int_osc_en | output | 1 | Internal oscillator enable |
| stopped | output | 1 | Block is in stop |
| stabilizing | output | 1 | Settling interval running |
| ack_valid | output | 1 | One-cycle pulse: branch to handler |
| next_instr | output | 1 | One-cycle pulse: continue at next instruction |
| ack_id | output | $clog2(N_IRQ+1) | Source being acknowledged, N_IRQ = non-maskable |
| held_valid | output | 1 | A waking request was left unacknowledged |
| held_id | output | $clog2(N_IRQ+1) | Index of the held request |

## Verification
Stop entry takes effect one edge after `stop_req` is sampled, and the settling state starts on the edge that samples a release. The resume pulse arrives exactly 2^(10+S) edges later. The driver records the cycle counter when it raises a release and queues the expected pulse kind, source index and exact cycle. A monitor on the falling edge pops each pulse and compares all three, so a pulse that is early, late, of the wrong kind or unexpected is reported. The clock enables, the stop flag and the held record are sampled one falling edge after the edge that changes them.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;
   typedef enum logic [1:0] {
      SW_RUN    = 2'd0,
      SW_STOP   = 2'd1,
      SW_STAB   = 2'd2,
      SW_RESUME = 2'd3
   } sw_state_e;
endpackage

// File: rtl/stopwake_arbiter.sv
// Picks the release source: non-maskable first, then highest priority
// value among unmasked requests, ties to the lowest index.
module stopwake_arbiter #(
   parameter int N_IRQ  = 4,
   parameter int PRIO_W = 3,
   parameter int IDW    = $clog2(N_IRQ + 1)
) (
   input  logic                      nmi,
   input  logic [N_IRQ-1:0]          req,
   input  logic [N_IRQ-1:0]          mask,
   input  logic [N_IRQ*PRIO_W-1:0]   prio_flat,
   output logic                      any,
   output logic                      win_nmi,
   output logic [IDW-1:0]            win_id,
   output logic [PRIO_W-1:0]         win_prio
);
   localparam logic [IDW-1:0] NMI_ID = IDW'(N_IRQ);

   logic [PRIO_W-1:0] prio_a [N_IRQ];
   logic [N_IRQ-1:0]  live;

   genvar g;
   generate
      for (g = 0; g < N_IRQ; g++) begin : g_unpack
         assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
         assign live[g]   = req[g] & ~mask[g];
      end
   endgenerate

   logic              best_v;
   logic [IDW-1:0]    best_id;
   logic [PRIO_W-1:0] best_p;

   always_comb begin
      best_v  = 1'b0;
      best_id = '0;
      best_p  = '0;
      for (int i = 0; i < N_IRQ; i++) begin
         if (live[i] && (!best_v || prio_a[i] > best_p)) begin
            best_v  = 1'b1;
            best_id = IDW'(i);
            best_p  = prio_a[i];
         end
      end
   end

   assign any      = nmi | best_v;
   assign win_nmi  = nmi;
   assign win_id   = nmi ? NMI_ID : best_id;
   assign win_prio = best_p;
endmodule

// File: rtl/stopwake_stab_timer.sv
// Settling counter on the reference clock: done on the last of 2^(BASE_EXP+sel) cycles.
module stopwake_stab_timer #(
   parameter int BASE_EXP = 10,
   parameter int SEL_W    = 3,
   parameter int CW       = BASE_EXP + (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);
   logic [CW-1:0] cnt;
   logic [CW:0]   span;
   logic [CW-1:0] last;

   assign span = (CW+1)'(1) << (BASE_EXP + int'(sel));
   assign last = CW'(span - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (run)   cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == last);
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl #(
   parameter int N_IRQ    = 4,
   parameter int PRIO_W   = 3,
   parameter int SEL_W    = 3,
   parameter int BASE_EXP = 10,
   parameter int IDW      = $clog2(N_IRQ + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stop_req,
   input  logic                    nmi_req,
   input  logic [N_IRQ-1:0]        irq_req,
   input  logic [N_IRQ-1:0]        irq_mask,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic                    isr_active,
   input  logic [PRIO_W-1:0]       isr_prio,
   input  logic                    int_en,
   input  logic [SEL_W-1:0]        stab_sel,
   output logic                    main_clk_en,
   output logic                    int_osc_en,
   output logic                    stopped,
   output logic                    stabilizing,
   output logic                    ack_valid,
   output logic                    next_instr,
   output logic [IDW-1:0]          ack_id,
   output logic                    held_valid,
   output logic [IDW-1:0]          held_id
);
   import stopwake_pkg::*;

   generate
      if (N_IRQ < 1)           begin : g_bad_n   $error("N_IRQ must be at least 1");    end
      if (PRIO_W < 1)          begin : g_bad_p   $error("PRIO_W must be at least 1");   end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_s $error("SEL_W must be 1..4");        end
      if (BASE_EXP < 1)        begin : g_bad_b   $error("BASE_EXP must be positive");   end
   endgenerate

   sw_state_e         state;
   logic              wake_any, wake_nmi;
   logic [IDW-1:0]    wake_id;
   logic [PRIO_W-1:0] wake_prio;
   logic              stab_done;
   logic              grant;
   logic              dec_ack;
   logic [IDW-1:0]    dec_id;
   logic [SEL_W-1:0]  sel_q;
   logic              isr_q;
   logic [PRIO_W-1:0] isr_prio_q;

   stopwake_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
      .nmi       (nmi_req),
      .req       (irq_req),
      .mask      (irq_mask),
      .prio_flat (irq_prio),
      .any       (wake_any),
      .win_nmi   (wake_nmi),
      .win_id    (wake_id),
      .win_prio  (wake_prio)
   );

   stopwake_stab_timer #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state != SW_STAB),
      .run   (state == SW_STAB),
      .sel   (sel_q),
      .done  (stab_done)
   );

   // Acknowledge: non-maskable always; maskable needs enable and
   // strictly higher priority than the routine in service at entry.
   assign grant = wake_nmi || (int_en && (!isr_q || wake_prio > isr_prio_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SW_RUN;
         dec_ack    <= 1'b0;
         dec_id     <= '0;
         sel_q      <= '0;
         isr_q      <= 1'b0;
         isr_prio_q <= '0;
         held_valid <= 1'b0;
         held_id    <= '0;
      end else begin
         unique case (state)
            SW_RUN: begin
               if (stop_req && !wake_any) begin
                  state      <= SW_STOP;
                  sel_q      <= stab_sel;
                  isr_q      <= isr_active;
                  isr_prio_q <= isr_prio;
                  held_valid <= 1'b0;
               end
            end
            SW_STOP: begin
               if (wake_any) begin
                  state   <= SW_STAB;
                  dec_ack <= grant;
                  dec_id  <= wake_id;
                  if (!grant) begin
                     held_valid <= 1'b1;
                     held_id    <= wake_id;
                  end
               end
            end
            SW_STAB: begin
               if (stab_done) state <= SW_RESUME;
            end
            SW_RESUME: state <= SW_RUN;
            default:   state <= SW_RUN;
         endcase
      end
   end

   assign stopped     = (state == SW_STOP);
   assign main_clk_en = (state != SW_STOP);
   assign int_osc_en  = (state != SW_STOP);
   assign stabilizing = (state == SW_STAB);
   assign ack_valid   = (state == SW_RESUME) &&  dec_ack;
   assign next_instr  = (state == SW_RESUME) && !dec_ack;
   assign ack_id      = dec_id;
endmodule

// File: rtl/stopwake_ctrl_chk.sv
module stopwake_ctrl_chk #(
   parameter int N_IRQ = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop_req,
   input logic             nmi_req,
   input logic [N_IRQ-1:0] irq_req,
   input logic [N_IRQ-1:0] irq_mask,
   input logic             main_clk_en,
   input logic             int_osc_en,
   input logic             stopped,
   input logic             stabilizing,
   input logic             ack_valid,
   input logic             next_instr
);
   logic release_src;
   logic pulse;
   assign release_src = nmi_req | (|(irq_req & ~irq_mask));
   assign pulse       = ack_valid | next_instr;

   assert_clocks_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> (!main_clk_en && !int_osc_en));

   assert_release_wakes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && release_src) |=> (stabilizing && main_clk_en));

   assert_masked_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !release_src) |=> stopped);

   assert_pulse_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(stabilizing));

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_valid && next_instr));

   assert_no_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && !stabilizing && !pulse && stop_req && release_src) |=> !stopped);
endmodule

bind stopwake_ctrl stopwake_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_req    (stop_req),
   .nmi_req     (nmi_req),
   .irq_req     (irq_req),
   .irq_mask    (irq_mask),
   .main_clk_en (main_clk_en),
   .int_osc_en  (int_osc_en),
   .stopped     (stopped),
   .stabilizing (stabilizing),
   .ack_valid   (ack_valid),
   .next_instr  (next_instr)
);

// File: tb/stopwake_ctrl_test.sv
`timescale 1ns/1ps
module stopwake_ctrl_test;
   localparam int N = 4;
   localparam int PW = 3;
   localparam int IDW = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req = 1'b0, nmi_req = 1'b0;
   logic [N-1:0] irq_req = '0, irq_mask = '0;
   logic [N*PW-1:0] irq_prio = '0;
   logic isr_active = 1'b0;
   logic [PW-1:0] isr_prio = '0;
   logic int_en = 1'b0;
   logic [2:0] stab_sel = '0;
   logic main_clk_en, int_osc_en, stopped, stabilizing, ack_valid, next_instr, held_valid;
   logic [IDW-1:0] ack_id, held_id;

   always #2 clk = ~clk;

   stopwake_ctrl uut (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .nmi_req(nmi_req),
      .irq_req(irq_req), .irq_mask(irq_mask), .irq_prio(irq_prio),
      .isr_active(isr_active), .isr_prio(isr_prio), .int_en(int_en),
      .stab_sel(stab_sel), .main_clk_en(main_clk_en), .int_osc_en(int_osc_en),
      .stopped(stopped), .stabilizing(stabilizing), .ack_valid(ack_valid),
      .next_instr(next_instr), .ack_id(ack_id), .held_valid(held_valid),
      .held_id(held_id)
   );

   typedef struct {
      bit     is_ack;
      int     id;
      longint cyc;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   longint cyc = 0;
   int     n_chk = 0, n_fail = 0;
   bit     finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Monitor: every resume pulse must match the head of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && (ack_valid || next_instr)) begin
         if (sb.size() == 0) begin
            check(0, "R8/R9 unexpected pulse", int'(cyc), -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(ack_valid == e.is_ack, {e.tag, " kind"}, int'(ack_valid), int'(e.is_ack));
            check(cyc == e.cyc, {e.tag, " cycle"}, int'(cyc), int'(e.cyc));
            if (e.is_ack) check(int'(ack_id) == e.id, {e.tag, " id"}, int'(ack_id), e.id);
         end
      end
   end

   function automatic logic [N*PW-1:0] pk(input int p0, p1, p2, p3);
      return {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
   endfunction

   task automatic enter_stop(input int sel, input bit isr_a, input int isr_p, input bit ie);
      @(negedge clk);
      stab_sel = 3'(sel); isr_active = isr_a; isr_prio = PW'(isr_p); int_en = ie;
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      check(stopped && !main_clk_en && !int_osc_en, "R2 stop gates clocks",
            int'({stopped, main_clk_en, int_osc_en}), 4);
   endtask

   task automatic wake(input int sel, input bit nmi, input logic [N-1:0] rq,
                       input logic [N-1:0] mk, input logic [N*PW-1:0] pr,
                       input bit exp_ack, input int exp_id, input string tag);
      exp_t e;
      nmi_req = nmi; irq_req = rq; irq_mask = mk; irq_prio = pr;
      e.is_ack = exp_ack; e.id = exp_id; e.tag = tag;
      e.cyc = cyc + 1 + (longint'(1) << (10 + sel));
      sb.push_back(e);
      @(negedge clk);
      nmi_req = 1'b0; irq_req = '0;
      check(stabilizing && main_clk_en && int_osc_en, "R3 clocks on while settling",
            int'({stabilizing, main_clk_en, int_osc_en}), 7);
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(main_clk_en && int_osc_en && !stopped && !ack_valid && !next_instr && !held_valid,
            "R11 reset state", int'({main_clk_en, int_osc_en, stopped, held_valid}), 12);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: enabled, no service routine, unmasked source 2 acknowledged after settling
      enter_stop(0, 0, 0, 1);
      wake(0, 0, 4'b0100, 4'b0000, pk(0, 0, 3, 0), 1, 2, "R7 enabled wake");

      // R1: masked request does not release; then non-maskable wakes (R5, id N)
      enter_stop(1, 0, 0, 1);
      irq_req = 4'b0010; irq_mask = 4'b0010; irq_prio = pk(0, 7, 0, 0);
      repeat (40) @(negedge clk);
      check(stopped && !main_clk_en, "R1 masked request keeps stop",
            int'({stopped, main_clk_en}), 2);
      wake(1, 1, 4'b0010, 4'b0010, pk(0, 7, 0, 0), 1, N, "R5 non-maskable wake");

      // R6: interrupts disabled, maskable wake continues at next instruction
      enter_stop(0, 0, 0, 0);
      wake(0, 0, 4'b0001, 4'b0000, pk(5, 0, 0, 0), 0, 0, "R6 disabled wake");

      // R6: disabled but non-maskable still acknowledged
      enter_stop(0, 0, 0, 0);
      wake(0, 1, 4'b0000, 4'b0000, pk(0, 0, 0, 0), 1, N, "R6 nmi while disabled");

      // R4: lower priority than the service routine: no ack, held recorded
      enter_stop(0, 1, 5, 1);
      wake(0, 0, 4'b0100, 4'b0000, pk(0, 0, 2, 0), 0, 0, "R4 lower priority wake");
      check(held_valid && held_id == 3'd2, "R4 held record",
            int'({held_valid, held_id}), 10);

      // R4: equal priority also not acknowledged
      enter_stop(0, 1, 4, 1);
      check(!held_valid, "R4 held cleared at entry", int'(held_valid), 0);
      wake(0, 0, 4'b1000, 4'b0000, pk(0, 0, 0, 4), 0, 0, "R4 equal priority wake");
      check(held_valid && held_id == 3'd3, "R4 held equal", int'({held_valid, held_id}), 11);

      // R5: higher priority than the service routine is acknowledged
      enter_stop(2, 1, 2, 1);
      wake(2, 0, 4'b0010, 4'b0000, pk(0, 6, 0, 0), 1, 1, "R5 higher priority wake");
      check(!held_valid, "R5 nothing held", int'(held_valid), 0);

      // R10: ties go to lowest index
      enter_stop(0, 0, 0, 1);
      wake(0, 0, 4'b1010, 4'b0000, pk(0, 3, 0, 3), 1, 1, "R10 tie lowest index");

      // R10: higher priority value beats lower index; masked higher one ignored
      enter_stop(0, 0, 0, 1);
      wake(0, 0, 4'b1011, 4'b0010, pk(1, 7, 0, 4), 1, 3, "R10 highest priority");

      // R10: non-maskable beats all
      enter_stop(0, 0, 0, 1);
      wake(0, 1, 4'b1111, 4'b0000, pk(7, 7, 7, 7), 1, N, "R10 nmi wins");

      // R9: release present with the stop command: no entry, no pulse
      @(negedge clk);
      int_en = 1'b1; isr_active = 1'b0;
      stop_req = 1'b1; irq_req = 4'b0001; irq_mask = 4'b0000; irq_prio = pk(2, 0, 0, 0);
      @(negedge clk);
      stop_req = 1'b0; irq_req = '0;
      check(!stopped && !stabilizing && main_clk_en && int_osc_en, "R9 entry blocked",
            int'({stopped, stabilizing, main_clk_en, int_osc_en}), 3);
      repeat (20) @(negedge clk);
      check(!stopped && sb.size() == 0, "R9 no later entry", int'(stopped), 0);

      finished = 1;
   end

   initial begin
      fork
         begin
            wait (finished);
         end
         begin
            repeat (200000) @(posedge clk);
            check(0, "watchdog expired", int'(cyc), 0);
         end
      join_any
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule